// File: doc/BRIEF.md
# I2C 10-bit address target receiver

This block is an I2C target that accepts write transfers addressed with 10-bit addressing. It brings the open-drain SCL and SDA lines into the system clock domain through flip-flop synchronizers, detects Start and Stop, and shifts in bytes MSB first. One 8-bit address-compare register, set by a host, is used for both address bytes. The first byte after a Start is compared with the high pattern. The second byte is compared with the low address.

Between the two address phases the host must reload the compare register. After the high byte matches, the host loads the low address. After the low byte, the host writes the high pattern back. While the block waits for each reload it holds SCL low. After the address it acknowledges every data byte and places it in a one-byte receive buffer. Clock stretching after each data byte is optional, and the host releases it with a clock-release bit. A Stop returns the block to idle.

The outputs `scl_hold_o` and `sda_ack_o` request a low level on the bus lines; the pad logic turns them into open-drain drivers.

Top module: `i2c10_target_rx`

## Requirements
- R1: A Start condition (SDA falling while SCL is high) sets `start_seen`. The same Start raises `irq_flag` only when `cfg_start_irq` is 1.
- R2: The first byte after a Start is compared with the compare register. The high pattern is 11110, A9, A8, R/W, received MSB first with R/W as bit 0. On a match the block acknowledges by pulling SDA low during the 9th SCL pulse, and sets `upd_addr` and `irq_flag`.
- R3: After each address byte, and after the 9th pulse ends, the block holds SCL low (`scl_hold_o`=1). The hold lasts until the host makes an accepted write to the compare register. That write releases SCL and clears `upd_addr`.
- R4: A host write to the compare register is ignored while the ACK sequence of the current byte is in progress. An ignored write does not release SCL.
- R5: When the second byte equals the compare register (the low address A7..A0), the block acknowledges it and sets `upd_addr` and `irq_flag` again.
- R6: When the second byte does not match, the block does not acknowledge it (SDA stays high on the 9th pulse). It still sets `upd_addr` and `irq_flag` and holds SCL until the host reloads the register. `buf_full` is not set and `clk_release` is unchanged. The rest of the transfer is then ignored.
- R7: Every acknowledged address or data byte is copied to `rx_byte` and sets `buf_full`. A `host_buf_rd` pulse clears `buf_full`.
- R8: Each data byte after a matched low address is acknowledged on the 9th SCL pulse, and `irq_flag` is set at that point. `irq_flag` stays set until the host pulses `host_flag_clr`.
- R9: When `cfg_stretch` is 1, the end of each data byte's 9th pulse clears `clk_release` and holds SCL low until the host pulses `host_rel_set`. When `cfg_stretch` is 0, no hold follows a data byte.
- R10: Data bytes are accepted one after another until a Stop (SDA rising while SCL is high). The Stop clears `start_seen` and `upd_addr`, releases SCL and returns the block to idle.
- R11: A first byte that differs from the compare register is not acknowledged. This includes the correct address with R/W=1. Such a byte sets no flag and causes no hold, and the bus is ignored until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| scl_hold_o | output | 1 | 1 requests SCL pulled low (stretch) |
| sda_ack_o | output | 1 | 1 requests SDA pulled low (acknowledge) |
| host_adr_wr | input | 1 | Write strobe for the compare register |
| host_adr_data | input | 8 | Value written to the compare register |
| host_rel_set | input | 1 | Pulse that sets the clock-release bit |
| host_buf_rd | input | 1 | Pulse marking a read of the receive buffer |
| host_flag_clr | input | 1 | Pulse that clears the interrupt flag |
| cfg_start_irq | input | 1 | Raise the interrupt flag on Start |
| cfg_stretch | input | 1 | Stretch SCL after each data byte |
| rx_byte | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| irq_flag | output | 1 | Interrupt flag |
| start_seen | output | 1 | Start detected since the last Stop |
| upd_addr | output | 1 | Compare register needs a reload |
| clk_release | output | 1 | Clock-release bit (0 = SCL held) |

## Verification
Errors in the reload and stretch state show up at the ports quickly. A hold flag that stays set when it should clear freezes the master at its next SCL release, one bit time after the host write. A hold that never sets lets the next byte clock in without a reload, and that byte then mismatches or lands in the buffer early. An off-by-one in the bit counter moves the acknowledge to the wrong clock, so SDA reads high on the 9th pulse of the same byte. Wrong flag updates (`buf_full` after a low mismatch, `upd_addr` surviving a Stop) are visible in the first idle cycles after that event. The scoreboard pairs every buffered byte with the byte the master sent, so a byte captured but never expected, or expected but never captured, is reported at the next transfer.

// File: rtl/i2c10_pkg.sv
// Shared types for the 10-bit address I2C target receiver.
// Assumes an I2C byte is always eight bits wide.
package i2c10_pkg;

    localparam int BYTE_W = 8;

    // Transfer phases seen by the control logic.
    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer addressed to this target
        ST_HI,     // receiving the first (high) address byte
        ST_LO,     // receiving the second (low) address byte
        ST_DATA,   // receiving data bytes
        ST_NACK,   // low address failed, finishing its 9th pulse
        ST_SKIP    // bus traffic not for this target, wait for Start
    } bus_st_e;

endpackage

// File: rtl/i2c10_line_sync.sv
// Synchronizes SCL and SDA into the clock domain and derives SCL edges
// and Start/Stop conditions from the synchronized levels.
// Assumes SYNC_STAGES >= 2 and that SDA only changes while SCL is low,
// except for Start and Stop.
module i2c10_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;   // index 1 = SCL, index 0 = SDA

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;
    logic              scl_s;
    logic              scl_q;
    logic              sda_q;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;

        // Shift chain moving one bus line into the clock domain (idle high).
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end

        assign synced[g] = chain[SYNC_STAGES-1];
    end

    // One-cycle delayed copy of both synchronized lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_q     = prev[1];
    assign sda_q     = prev[0];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c10_byte_rx.sv
// Bit counter and shift register for one I2C byte plus its 9th (ACK)
// pulse. Pulses byte_done on the SCL fall after bit 8 and ack_end on the
// SCL fall after the 9th pulse.
// Assumes edges arrive from i2c10_line_sync; restart clears the count.
module i2c10_byte_rx
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              restart,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    output logic              byte_done,
    output logic              ack_end,
    output logic              in_ack,
    output logic [BYTE_W-1:0] shreg
);

    localparam int            CW   = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);

    logic [CW-1:0] bitcnt;

    assign byte_done = active & scl_fall & ~in_ack & (bitcnt == FULL);
    assign ack_end   = active & scl_fall & in_ack;

    // Shift in data bits on SCL rise and step through the ACK pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            in_ack <= 1'b0;
            shreg  <= '0;
        end else if (restart || !active) begin
            bitcnt <= '0;
            in_ack <= 1'b0;
        end else if (scl_rise && !in_ack && bitcnt != FULL) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
        end else if (byte_done) begin
            in_ack <= 1'b1;
        end else if (ack_end) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
        end
    end

    // R8: the ACK phase only exists after a complete byte.
    a_r8_ack_after_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack |-> (bitcnt == FULL));

    // R8: the ACK phase begins only on an SCL falling edge.
    a_r8_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(scl_fall));

endmodule

// File: rtl/i2c10_host_regs.sv
// Host-side address-compare register. A write is accepted only outside
// the ACK sequence of the byte in progress; adr_wr_ok tells the control
// logic that a reload took effect.
module i2c10_host_regs
    import i2c10_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_adr_wr,
    input  logic [BYTE_W-1:0] host_adr_data,
    input  logic              in_ack,
    output logic              adr_wr_ok,
    output logic [BYTE_W-1:0] adr_q
);

    assign adr_wr_ok = host_adr_wr & ~in_ack;

    // Compare register updated by accepted host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         adr_q <= RESET_ADDR;
        else if (adr_wr_ok) adr_q <= host_adr_data;
    end

    // R4: a write during the ACK sequence leaves the register untouched.
    a_r4_ack_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_adr_wr && in_ack) |=> $stable(adr_q));

endmodule

// File: rtl/i2c10_rx_ctrl.sv
// Transfer control: tracks the address phases, decides ACK/NACK at each
// byte boundary, and owns the status flags, receive buffer, clock-release
// bit and address-reload hold.
// Assumes byte_done/ack_end come from i2c10_byte_rx and the compare value
// from i2c10_host_regs.
module i2c10_rx_ctrl
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_done,
    input  logic              ack_end,
    input  logic [BYTE_W-1:0] shreg,
    input  logic [BYTE_W-1:0] adr_q,
    input  logic              adr_wr_ok,
    input  logic              rel_set,
    input  logic              buf_rd,
    input  logic              flag_clr,
    input  logic              cfg_start_irq,
    input  logic              cfg_stretch,
    output logic              active,
    output logic              ack_en,
    output logic              wait_adr,
    output logic              ckp,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              buf_full,
    output logic              irq_flag,
    output logic              start_seen,
    output logic              upd_addr
);

    bus_st_e state;
    logic    match;
    logic    hi_ok;
    logic    lo_ok;
    logic    lo_bad;
    logic    dat_ok;
    logic    byte_set;
    logic    hold_pend;
    logic    ckp_pend;

    assign match    = (shreg == adr_q);
    assign hi_ok    = byte_done && state == ST_HI && match;
    assign lo_ok    = byte_done && state == ST_LO && match;
    assign lo_bad   = byte_done && state == ST_LO && !match;
    assign dat_ok   = byte_done && state == ST_DATA;
    assign byte_set = hi_ok | lo_ok | dat_ok;
    assign active   = state inside {ST_HI, ST_LO, ST_DATA, ST_NACK};

    // Phase sequencing across Start, address bytes, data and Stop.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_det) begin
            state <= ST_IDLE;
        end else if (start_det) begin
            state <= ST_HI;
        end else if (byte_done) begin
            case (state)
                ST_HI:   state <= match ? ST_LO : ST_SKIP;
                ST_LO:   state <= match ? ST_DATA : ST_NACK;
                default: state <= state;
            endcase
        end else if (ack_end && state == ST_NACK) begin
            state <= ST_SKIP;
        end
    end

    // Per-byte decisions held across the 9th pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_det || start_det || ack_end) begin
            ack_en    <= 1'b0;
            hold_pend <= 1'b0;
            ckp_pend  <= 1'b0;
        end else if (byte_done) begin
            ack_en    <= byte_set;
            hold_pend <= hi_ok | lo_ok | lo_bad;
            ckp_pend  <= dat_ok & cfg_stretch;
        end
    end

    // SCL hold sources: address reload wait and the clock-release bit.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_det) begin
            wait_adr <= 1'b0;
            ckp      <= 1'b1;
        end else begin
            if (ack_end && hold_pend) wait_adr <= 1'b1;
            else if (adr_wr_ok)       wait_adr <= 1'b0;
            if (ack_end && ckp_pend)  ckp <= 1'b0;
            else if (rel_set)         ckp <= 1'b1;
        end
    end

    // Update-address flag: set per address byte, cleared by reload or Stop.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_det)          upd_addr <= 1'b0;
        else if (hi_ok | lo_ok | lo_bad) upd_addr <= 1'b1;
        else if (adr_wr_ok)              upd_addr <= 1'b0;
    end

    // Interrupt flag: hardware set has priority over host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (byte_set | lo_bad | (start_det & cfg_start_irq))
            irq_flag <= 1'b1;
        else if (flag_clr)
            irq_flag <= 1'b0;
    end

    // Receive buffer and its full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            buf_full <= 1'b0;
        end else if (byte_set) begin
            rx_byte  <= shreg;
            buf_full <= 1'b1;
        end else if (buf_rd) begin
            buf_full <= 1'b0;
        end
    end

    // Start status bit, live between Start and Stop.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_det) start_seen <= 1'b0;
        else if (start_det)     start_seen <= 1'b1;
    end

    // R2: a matched high byte raises all three flags.
    a_r2_high_match_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ok |=> (upd_addr && irq_flag && buf_full));

    // R6: a low mismatch leaves the buffer flag and clock-release bit alone.
    a_r6_mismatch_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_bad && !buf_rd && !rel_set) |=>
            (buf_full == $past(buf_full) && ckp == $past(ckp) && upd_addr && irq_flag));

    // R7: a host read with no new byte empties the buffer.
    a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !byte_set) |=> !buf_full);

    // R10: a Stop returns to idle with no hold and no pending reload.
    a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !upd_addr && !start_seen && !wait_adr && ckp));

endmodule

// File: rtl/i2c10_target_rx.sv
// Top of the 10-bit address I2C target receiver. Connects line
// synchronization, byte reception, the host compare register and the
// transfer control. Outputs request a low level on SCL/SDA; the pad
// logic outside builds the open-drain drivers.
module i2c10_target_rx #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] RESET_ADDR  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_hold_o,
    output logic       sda_ack_o,
    input  logic       host_adr_wr,
    input  logic [7:0] host_adr_data,
    input  logic       host_rel_set,
    input  logic       host_buf_rd,
    input  logic       host_flag_clr,
    input  logic       cfg_start_irq,
    input  logic       cfg_stretch,
    output logic [7:0] rx_byte,
    output logic       buf_full,
    output logic       irq_flag,
    output logic       start_seen,
    output logic       upd_addr,
    output logic       clk_release
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       byte_done;
    logic       ack_end;
    logic       in_ack;
    logic [7:0] shreg;
    logic       adr_wr_ok;
    logic [7:0] adr_q;
    logic       active;
    logic       ack_en;
    logic       wait_adr;
    logic       ckp;

    i2c10_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c10_byte_rx u_byte (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .restart   (start_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .byte_done (byte_done),
        .ack_end   (ack_end),
        .in_ack    (in_ack),
        .shreg     (shreg)
    );

    i2c10_host_regs #(
        .RESET_ADDR (RESET_ADDR)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_adr_wr   (host_adr_wr),
        .host_adr_data (host_adr_data),
        .in_ack        (in_ack),
        .adr_wr_ok     (adr_wr_ok),
        .adr_q         (adr_q)
    );

    i2c10_rx_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .byte_done     (byte_done),
        .ack_end       (ack_end),
        .shreg         (shreg),
        .adr_q         (adr_q),
        .adr_wr_ok     (adr_wr_ok),
        .rel_set       (host_rel_set),
        .buf_rd        (host_buf_rd),
        .flag_clr      (host_flag_clr),
        .cfg_start_irq (cfg_start_irq),
        .cfg_stretch   (cfg_stretch),
        .active        (active),
        .ack_en        (ack_en),
        .wait_adr      (wait_adr),
        .ckp           (ckp),
        .rx_byte       (rx_byte),
        .buf_full      (buf_full),
        .irq_flag      (irq_flag),
        .start_seen    (start_seen),
        .upd_addr      (upd_addr)
    );

    assign scl_hold_o  = wait_adr | ~ckp;
    assign sda_ack_o   = in_ack & ack_en;
    assign clk_release = ckp;

    // R3/R9: SCL is released only by a reload, a release pulse or a Stop.
    a_r3_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hold_o) |-> $past(adr_wr_ok || host_rel_set || stop_det));

endmodule

// File: tb/test_i2c10_target_rx.sv
// Scoreboard bench: the bus driver pushes each byte the target should
// buffer; a monitor pops and compares whenever buf_full is raised.
module test_i2c10_target_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_line;
    logic       sda_line;
    logic       scl_hold_o;
    logic       sda_ack_o;
    logic       host_adr_wr = 1'b0;
    logic [7:0] host_adr_data = 8'h00;
    logic       host_rel_set = 1'b0;
    logic       host_buf_rd = 1'b0;
    logic       host_flag_clr = 1'b0;
    logic       cfg_start_irq = 1'b0;
    logic       cfg_stretch = 1'b0;
    logic [7:0] rx_byte;
    logic       buf_full;
    logic       irq_flag;
    logic       start_seen;
    logic       upd_addr;
    logic       clk_release;

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];

    localparam logic [7:0] HI_ADR = 8'hF4;   // 11110 A9=1 A8=0 R/W=0
    localparam logic [7:0] LO_ADR = 8'hA5;

    always #4 clk = ~clk;

    assign scl_line = scl_m & ~scl_hold_o;
    assign sda_line = sda_m & ~sda_ack_o;

    i2c10_target_rx i_i2c10_target_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .scl_hold_o    (scl_hold_o),
        .sda_ack_o     (sda_ack_o),
        .host_adr_wr   (host_adr_wr),
        .host_adr_data (host_adr_data),
        .host_rel_set  (host_rel_set),
        .host_buf_rd   (host_buf_rd),
        .host_flag_clr (host_flag_clr),
        .cfg_start_irq (cfg_start_irq),
        .cfg_stretch   (cfg_stretch),
        .rx_byte       (rx_byte),
        .buf_full      (buf_full),
        .irq_flag      (irq_flag),
        .start_seen    (start_seen),
        .upd_addr      (upd_addr),
        .clk_release   (clk_release)
    );

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        while (!scl_line && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk_eq("R3 SCL stretch timeout", 32'(scl_line), 32'd1);
    endtask

    task automatic host_write(input logic [7:0] d);
        host_adr_wr   = 1'b1;
        host_adr_data = d;
        @(negedge clk);
        host_adr_wr   = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rel();
        host_rel_set = 1'b1;
        @(negedge clk);
        host_rel_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        host_flag_clr = 1'b1;
        @(negedge clk);
        host_flag_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0;
        cyc(8);
        scl_m = 1'b0;
        cyc(8);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        cyc(4);
        scl_m = 1'b1;
        wait_scl_high();
        cyc(8);
        sda_m = 1'b1;
        cyc(8);
    endtask

    // Eight data bits MSB first plus the 9th pulse; returns the sampled ACK.
    task automatic send_byte(input logic [7:0] b, input bit wr_in_ack, output logic ackbit);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            cyc(4);
            scl_m = 1'b1;
            wait_scl_high();
            cyc(8);
            scl_m = 1'b0;
            cyc(4);
        end
        sda_m = 1'b1;
        cyc(4);
        scl_m = 1'b1;
        wait_scl_high();
        cyc(4);
        ackbit = sda_line;
        if (wr_in_ack) host_write(8'h00);
        else           cyc(2);
        cyc(2);
        scl_m = 1'b0;
        cyc(8);
    endtask

    // Monitor: compare each buffered byte with the scoreboard and read it.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && buf_full && !done) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7 unexpected buffered byte actual=%0h expected=none", rx_byte);
                end else begin
                    chk_eq("R7 buffered byte", 32'(rx_byte), 32'(exp_q.pop_front()));
                end
                host_buf_rd = 1'b1;
                @(negedge clk);
                host_buf_rd = 1'b0;
                @(negedge clk);
                chk_eq("R7 read clears buf_full", 32'(buf_full), 32'd0);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // Reset state
        chk_eq("R10 reset scl_hold_o", 32'(scl_hold_o), 32'd0);
        chk_eq("R8 reset sda_ack_o", 32'(sda_ack_o), 32'd0);
        chk_eq("R7 reset buf_full", 32'(buf_full), 32'd0);
        chk_eq("R8 reset irq_flag", 32'(irq_flag), 32'd0);
        chk_eq("R10 reset upd_addr", 32'(upd_addr), 32'd0);
        chk_eq("R9 reset clk_release", 32'(clk_release), 32'd1);
        chk_eq("R1 reset start_seen", 32'(start_seen), 32'd0);

        host_write(HI_ADR);

        // Transfer 1: full matched write, start interrupt disabled.
        bus_start();
        chk_eq("R1 start_seen after Start", 32'(start_seen), 32'd1);
        chk_eq("R1 no irq with start irq disabled", 32'(irq_flag), 32'd0);
        exp_q.push_back(HI_ADR);
        send_byte(HI_ADR, 1'b1, ack);
        chk_eq("R2 high byte acknowledged", 32'(ack), 32'd0);
        chk_eq("R2 upd_addr after high", 32'(upd_addr), 32'd1);
        chk_eq("R2 irq after high", 32'(irq_flag), 32'd1);
        chk_eq("R4 write during ACK leaves SCL held", 32'(scl_hold_o), 32'd1);
        chk_eq("R7 high byte consumed", exp_q.size(), 32'd0);
        pulse_clr();
        chk_eq("R8 host clear drops irq", 32'(irq_flag), 32'd0);
        host_write(LO_ADR);
        chk_eq("R3 reload releases SCL", 32'(scl_hold_o), 32'd0);
        chk_eq("R3 reload clears upd_addr", 32'(upd_addr), 32'd0);

        exp_q.push_back(LO_ADR);
        send_byte(LO_ADR, 1'b0, ack);
        chk_eq("R5 low byte acknowledged", 32'(ack), 32'd0);
        chk_eq("R5 upd_addr after low", 32'(upd_addr), 32'd1);
        chk_eq("R5 irq after low", 32'(irq_flag), 32'd1);
        chk_eq("R3 SCL held after low", 32'(scl_hold_o), 32'd1);
        pulse_clr();
        host_write(HI_ADR);
        chk_eq("R3 high restore releases SCL", 32'(scl_hold_o), 32'd0);

        for (int k = 0; k < 2; k++) begin
            logic [7:0] d;
            d = (k == 0) ? 8'h3C : 8'h81;
            exp_q.push_back(d);
            send_byte(d, 1'b0, ack);
            chk_eq("R8 data byte acknowledged", 32'(ack), 32'd0);
            chk_eq("R8 irq after data", 32'(irq_flag), 32'd1);
            chk_eq("R9 no hold without stretch", 32'(scl_hold_o), 32'd0);
            chk_eq("R9 clk_release stays set", 32'(clk_release), 32'd1);
            pulse_clr();
        end

        cfg_stretch = 1'b1;
        exp_q.push_back(8'h5A);
        send_byte(8'h5A, 1'b0, ack);
        chk_eq("R10 third data byte acknowledged", 32'(ack), 32'd0);
        chk_eq("R9 stretch clears clk_release", 32'(clk_release), 32'd0);
        chk_eq("R9 stretch holds SCL", 32'(scl_hold_o), 32'd1);
        pulse_rel();
        chk_eq("R9 release pulse frees SCL", 32'(scl_hold_o), 32'd0);
        cfg_stretch = 1'b0;
        pulse_clr();
        bus_stop();
        chk_eq("R10 Stop clears start_seen", 32'(start_seen), 32'd0);
        chk_eq("R10 Stop leaves SCL free", 32'(scl_hold_o), 32'd0);
        chk_eq("R7 all bytes consumed", exp_q.size(), 32'd0);

        // Transfer 2: other high address, start interrupt enabled.
        cfg_start_irq = 1'b1;
        bus_start();
        chk_eq("R1 irq on Start when enabled", 32'(irq_flag), 32'd1);
        pulse_clr();
        send_byte(8'hF6, 1'b0, ack);
        chk_eq("R11 foreign high byte not acknowledged", 32'(ack), 32'd1);
        chk_eq("R11 no irq on foreign byte", 32'(irq_flag), 32'd0);
        chk_eq("R11 no hold on foreign byte", 32'(scl_hold_o), 32'd0);
        chk_eq("R11 no upd_addr on foreign byte", 32'(upd_addr), 32'd0);
        send_byte(8'h11, 1'b0, ack);
        chk_eq("R11 later bytes ignored", 32'(ack), 32'd1);
        bus_stop();
        cfg_start_irq = 1'b0;
        pulse_clr();

        // Transfer 3: own address with R/W=1.
        bus_start();
        send_byte(HI_ADR | 8'h01, 1'b0, ack);
        chk_eq("R11 read request not acknowledged", 32'(ack), 32'd1);
        chk_eq("R11 no flags on read request", 32'(irq_flag), 32'd0);
        bus_stop();

        // Transfer 4: high match, low mismatch.
        bus_start();
        exp_q.push_back(HI_ADR);
        send_byte(HI_ADR, 1'b0, ack);
        chk_eq("R2 high byte acknowledged again", 32'(ack), 32'd0);
        pulse_clr();
        host_write(LO_ADR);
        send_byte(8'h77, 1'b0, ack);
        chk_eq("R6 low mismatch not acknowledged", 32'(ack), 32'd1);
        chk_eq("R6 upd_addr still set", 32'(upd_addr), 32'd1);
        chk_eq("R6 irq still set", 32'(irq_flag), 32'd1);
        chk_eq("R6 buf_full not set", 32'(buf_full), 32'd0);
        chk_eq("R6 clk_release unchanged", 32'(clk_release), 32'd1);
        chk_eq("R6 SCL held for restore", 32'(scl_hold_o), 32'd1);
        host_write(HI_ADR);
        chk_eq("R6 restore releases SCL", 32'(scl_hold_o), 32'd0);
        pulse_clr();
        send_byte(8'h22, 1'b0, ack);
        chk_eq("R6 rest of transfer ignored", 32'(ack), 32'd1);
        bus_stop();
        chk_eq("R10 Stop clears upd_addr", 32'(upd_addr), 32'd0);

        // Transfer 5: restored high address matches again.
        bus_start();
        exp_q.push_back(HI_ADR);
        send_byte(HI_ADR, 1'b0, ack);
        chk_eq("R6 restored high address acknowledged", 32'(ack), 32'd0);
        pulse_clr();
        host_write(LO_ADR);
        bus_stop();
        chk_eq("R10 idle after final Stop", 32'(scl_hold_o), 32'd0);
        chk_eq("R7 scoreboard empty at end", exp_q.size(), 32'd0);

        done = 1'b1;
        cyc(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule